// File: doc/BRIEF.md
# Metering Package Stream Receiver

This block sits on the controller side of a byte link from an energy-metering signal processor. The processor sends packages in bursts. Each burst is marked by a data-ready line that goes high for its whole length. The receiver watches that line and a byte strobe. It checks the leading synchronisation byte of each burst and decodes the package code from the second byte. For a data package it keeps the mode byte, the status byte and twelve payload bytes in a shadow buffer. When the final byte arrives, it moves all of them at once into output registers tagged with the package number.

Two codes are special. One code announces that the processor is waiting for calibration data; such a burst carries only a header and raises a one-cycle event. The other code announces a power failure; two complete packages then follow back to back and are captured as billing data. The receiver also tracks the order of normal packages, which run through six numbers and then wrap to the first. It flags a bad sync byte, a break in the order, and a burst that ends early. All error flags clear when the next burst begins.

The byte input cannot be stalled, because the link has no ready signal toward the sender. A strobed byte is taken in the cycle it is presented. The output side likewise has no ready: `pkg_valid` is a one-cycle pulse and the captured registers hold their contents until the next complete package. A consumer that misses the pulse can still read the held values.

Top module: `meter_pkg_rx`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero until a package or event is received.
- R2: A burst is accepted only if the first strobed byte after the data-ready rise equals 8'h80. Any other value sets `sync_err`, and that burst produces no capture and no event.
- R3: A package is 16 bytes in this order: sync byte, code byte, mode byte, status byte, then payload bytes 0 to 11. A code (bits 2:0 of the second byte) of 0 to 5 is a normal package with that number. `pkg_valid` pulses for exactly one cycle after the clock edge that takes the 16th byte. `pkg_num`, `pkg_mode` and `pkg_status` then hold the captured values, and payload byte k is at `pkg_payload[8k+7:8k]`. Bits 7:3 of the code byte have no effect.
- R4: The captured outputs change only together with a `pkg_valid` pulse. Bytes strobed after the 16th byte of a normal package in the same burst are ignored.
- R5: Code 6 pulses `cal_evt` for one cycle after the code byte is taken. No capture follows, and the rest of that burst is ignored.
- R6: Code 7 pulses `pf_evt` for one cycle and starts a billing burst. That package (16 bytes) is captured as number 3. A second 16-byte package follows with its own 8'h80 sync byte; its code is ignored and it is captured as number 4. Both captures set `pkg_bill`. Billing packages do not take part in the order check.
- R7: A normal package whose number is not the previous normal number plus one (5 wraps to 0) sets `seq_err`, and the package is still captured. The first normal package after reset is exempt.
- R8: If data-ready falls after the sync byte of a package has been taken and before its 16th byte, or between the two billing packages, the partial package is dropped with no `pkg_valid`, and `len_err` is set. A burst that ends with no bytes, after a completed package, or after a calibration header sets no error.
- R9: `sync_err`, `seq_err` and `len_err` hold until the next data-ready rise, and are low from the cycle after that rise.
- R10: Strobes while data-ready is low are ignored, and so is a strobe in the same cycle as the data-ready rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_stb | input | 1 | Byte strobe, one cycle per byte |
| data_rdy | input | 1 | High for the duration of a burst |
| pkg_valid | output | 1 | One-cycle pulse when a package is captured |
| pkg_num | output | 3 | Number of the captured package |
| pkg_bill | output | 1 | Captured package is billing data |
| pkg_mode | output | 8 | Captured mode byte |
| pkg_status | output | 8 | Captured status byte |
| pkg_payload | output | 96 | Captured payload, byte k at bits 8k+7:8k |
| cal_evt | output | 1 | One-cycle calibration request event |
| pf_evt | output | 1 | One-cycle power-fail event |
| sync_err | output | 1 | First byte of burst was not 8'h80 |
| seq_err | output | 1 | Normal package out of order |
| len_err | output | 1 | Burst ended inside a package |

## Verification
The bench builds the block with its default parameters: twelve payload bytes and six normal package numbers. With only three code bits, this lets it sweep every code value. It runs normal packages under all 32 patterns of the ignored upper code bits, which carries the order check through five full wraps. It also covers every truncation length that matters, six wrong sync values, and both the complete and the truncated forms of the power-fail pair. Payload, mode and status bytes are formed from a per-package seed, so the bench can compute each expected field with a short formula.

// File: rtl/meter_rx_pkg.sv
package meter_rx_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_CAL = 3'd6;
  localparam logic [CODE_W-1:0] CODE_PF = 3'd7;
  localparam logic [CODE_W-1:0] BILL_FIRST = 3'd3;
  localparam logic [CODE_W-1:0] BILL_SECOND = 3'd4;
  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_SYNC,
    ST_BODY,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/rx_level_edge.sv
module rx_level_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/rx_order_track.sv
module rx_order_track #(
  parameter int NPKG  = 6,
  parameter int NUM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [NUM_W-1:0] num,
  output logic             mismatch
);
  logic [NUM_W-1:0] prev;
  logic             have_prev;
  logic [NUM_W-1:0] nxt;

  assign nxt = (prev == NUM_W'(NPKG - 1)) ? '0 : prev + 1'b1;
  assign mismatch = have_prev && (num != nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
    end else if (commit) begin
      prev      <= num;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_pay_shadow.sv
module rx_pay_shadow #(
  parameter int N  = 11,
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  din,
  output logic [N*W-1:0] flat
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] ent;
    always_ff @(posedge clk) begin
      if (!rst_n)                       ent <= '0;
      else if (we && idx == IW'(g))     ent <= din;
    end
    assign flat[g*W +: W] = ent;
  end
endmodule

// File: rtl/meter_pkg_rx.sv
module meter_pkg_rx
  import meter_rx_pkg::*;
#(
  parameter int          PAY    = 12,
  parameter int          NPKG   = 6,
  parameter int          BYTE_W = 8,
  parameter logic [7:0]  SYNC   = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  rx_stb,
  input  logic                  data_rdy,
  output logic                  pkg_valid,
  output logic [CODE_W-1:0]     pkg_num,
  output logic                  pkg_bill,
  output logic [BYTE_W-1:0]     pkg_mode,
  output logic [BYTE_W-1:0]     pkg_status,
  output logic [PAY*BYTE_W-1:0] pkg_payload,
  output logic                  cal_evt,
  output logic                  pf_evt,
  output logic                  sync_err,
  output logic                  seq_err,
  output logic                  len_err
);
  localparam int PKG_LEN = PAY + HDR_BYTES;
  localparam int CNT_W   = $clog2(PKG_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKG_LEN - 1);

  rx_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic                  bill, second;
  logic [CODE_W-1:0]     cur_num;
  logic [BYTE_W-1:0]     sh_mode, sh_status;
  logic                  rise, fall, take, mismatch;
  logic                  body_take, commit_norm, pay_we;
  logic [CODE_W-1:0]     code;
  logic [CNT_W-1:0]      pay_idx;
  logic [(PAY-1)*BYTE_W-1:0] pay_flat;

  rx_level_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(data_rdy), .rise(rise), .fall(fall)
  );

  assign take        = rx_stb && data_rdy && !rise;
  assign body_take   = take && (state == ST_BODY);
  assign code        = rx_byte[CODE_W-1:0];
  assign commit_norm = body_take && (cnt == LAST) && !bill;
  assign pay_we      = body_take && (cnt >= CNT_W'(HDR_BYTES));
  assign pay_idx     = cnt - CNT_W'(HDR_BYTES);

  rx_order_track #(.NPKG(NPKG), .NUM_W(CODE_W)) u_order (
    .clk(clk), .rst_n(rst_n), .commit(commit_norm), .num(cur_num),
    .mismatch(mismatch)
  );

  rx_pay_shadow #(.N(PAY - 1), .W(BYTE_W), .IW(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(pay_we), .idx(pay_idx), .din(rx_byte),
    .flat(pay_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_OFF;
      cnt         <= '0;
      bill        <= 1'b0;
      second      <= 1'b0;
      cur_num     <= '0;
      sh_mode     <= '0;
      sh_status   <= '0;
      pkg_valid   <= 1'b0;
      pkg_num     <= '0;
      pkg_bill    <= 1'b0;
      pkg_mode    <= '0;
      pkg_status  <= '0;
      pkg_payload <= '0;
      cal_evt     <= 1'b0;
      pf_evt      <= 1'b0;
      sync_err    <= 1'b0;
      seq_err     <= 1'b0;
      len_err     <= 1'b0;
    end else begin
      pkg_valid <= 1'b0;
      cal_evt   <= 1'b0;
      pf_evt    <= 1'b0;
      if (rise) begin
        state    <= ST_SYNC;
        cnt      <= '0;
        bill     <= 1'b0;
        second   <= 1'b0;
        sync_err <= 1'b0;
        seq_err  <= 1'b0;
        len_err  <= 1'b0;
      end else if (fall) begin
        if (state == ST_BODY || (state == ST_SYNC && second)) len_err <= 1'b1;
        state <= ST_OFF;
      end else if (take) begin
        case (state)
          ST_SYNC: begin
            if (rx_byte == SYNC) begin
              state <= ST_BODY;
              cnt   <= CNT_W'(1);
            end else begin
              sync_err <= 1'b1;
              state    <= ST_SKIP;
            end
          end
          ST_BODY: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              if (second) cur_num <= BILL_SECOND;
              else if (code == CODE_CAL) begin
                cal_evt <= 1'b1;
                state   <= ST_SKIP;
              end else if (code == CODE_PF) begin
                pf_evt  <= 1'b1;
                bill    <= 1'b1;
                cur_num <= BILL_FIRST;
              end else cur_num <= code;
            end
            if (cnt == CNT_W'(2)) sh_mode   <= rx_byte;
            if (cnt == CNT_W'(3)) sh_status <= rx_byte;
            if (cnt == LAST) begin
              pkg_valid   <= 1'b1;
              pkg_num     <= cur_num;
              pkg_bill    <= bill;
              pkg_mode    <= sh_mode;
              pkg_status  <= sh_status;
              pkg_payload <= {rx_byte, pay_flat};
              if (!bill && mismatch) seq_err <= 1'b1;
              if (bill && !second) begin
                second <= 1'b1;
                state  <= ST_SYNC;
                cnt    <= '0;
              end else state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/meter_pkg_rx_chk.sv
module meter_pkg_rx_chk #(
  parameter int PAY  = 12,
  parameter int NPKG = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           data_rdy,
  input logic           pkg_valid,
  input logic [2:0]     pkg_num,
  input logic           pkg_bill,
  input logic [7:0]     pkg_mode,
  input logic [7:0]     pkg_status,
  input logic [PAY*8-1:0] pkg_payload,
  input logic           cal_evt,
  input logic           pf_evt,
  input logic           sync_err,
  input logic           seq_err,
  input logic           len_err
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_valid |=> !pkg_valid); // R3
  AST_NUM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_valid && !pkg_bill |-> pkg_num < 3'(NPKG)); // R3
  AST_NO_CAPTURE_AFTER_BAD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !pkg_valid); // R2
  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkg_valid |-> $stable(pkg_num) && $stable(pkg_bill) && $stable(pkg_mode)
                   && $stable(pkg_status) && $stable(pkg_payload)); // R4
  AST_CAL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_evt |-> !pkg_valid); // R5
  AST_PF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_evt |=> !pf_evt); // R6
  AST_BILL_NUMBERS: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_valid && pkg_bill |-> (pkg_num == 3'd3 || pkg_num == 3'd4)); // R6
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |=> !sync_err && !seq_err && !len_err); // R9
  AST_QUIET_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |=> !pkg_valid); // R10
endmodule

bind meter_pkg_rx meter_pkg_rx_chk #(.PAY(PAY), .NPKG(NPKG)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_rdy(data_rdy), .pkg_valid(pkg_valid),
  .pkg_num(pkg_num), .pkg_bill(pkg_bill), .pkg_mode(pkg_mode),
  .pkg_status(pkg_status), .pkg_payload(pkg_payload), .cal_evt(cal_evt),
  .pf_evt(pf_evt), .sync_err(sync_err), .seq_err(seq_err), .len_err(len_err)
);

// File: tb/test_meter_pkg_rx.sv
module test_meter_pkg_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rx_stb = 1'b0, data_rdy = 1'b0;
  logic pkg_valid, pkg_bill, cal_evt, pf_evt, sync_err, seq_err, len_err;
  logic [2:0] pkg_num;
  logic [7:0] pkg_mode, pkg_status;
  logic [95:0] pkg_payload;
  int total = 0, bad = 0, vcnt = 0, ccnt = 0, pcnt = 0;

  always #2 clk = ~clk;

  meter_pkg_rx i_meter_pkg_rx (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_stb(rx_stb),
    .data_rdy(data_rdy), .pkg_valid(pkg_valid), .pkg_num(pkg_num),
    .pkg_bill(pkg_bill), .pkg_mode(pkg_mode), .pkg_status(pkg_status),
    .pkg_payload(pkg_payload), .cal_evt(cal_evt), .pf_evt(pf_evt),
    .sync_err(sync_err), .seq_err(seq_err), .len_err(len_err)
  );

  always @(negedge clk) begin
    if (pkg_valid) vcnt++;
    if (cal_evt)   ccnt++;
    if (pf_evt)    pcnt++;
  end

  task automatic chk(input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic rdy_up;
    data_rdy = 1'b1; tick; tick;
  endtask

  task automatic rdy_down;
    data_rdy = 1'b0; tick; tick;
  endtask

  task automatic put(input logic [7:0] b);
    rx_byte = b; rx_stb = 1'b1; tick; rx_stb = 1'b0;
  endtask

  function automatic logic [7:0] f_mode(input int s); return 8'(s) ^ 8'h5A; endfunction
  function automatic logic [7:0] f_stat(input int s); return 8'(s * 3 + 1); endfunction
  function automatic logic [7:0] f_pay(input int s, input int k);
    return 8'(s * 7 + k * 13 + 1);
  endfunction

  function automatic logic [7:0] byte_at(input logic [7:0] first, input logic [7:0] code,
                                         input int s, input int i);
    if (i == 0) return first;
    if (i == 1) return code;
    if (i == 2) return f_mode(s);
    if (i == 3) return f_stat(s);
    return f_pay(s, i - 4);
  endfunction

  task automatic send_raw(input logic [7:0] first, input logic [7:0] code,
                          input int s, input int from, input int n);
    for (int i = from; i < n; i++) put(byte_at(first, code, s, i));
  endtask

  task automatic send_pkg(input logic [7:0] code, input int s, input int n);
    send_raw(8'h80, code, s, 0, n);
  endtask

  task automatic check_pkg(input string req, input int num, input int s, input bit bl);
    logic [95:0] ep;
    for (int k = 0; k < 12; k++) ep[8*k +: 8] = f_pay(s, k);
    chk(req, "pkg_num", 96'(pkg_num), 96'(num));
    chk(req, "pkg_bill", 96'(pkg_bill), 96'(bl));
    chk(req, "pkg_mode", 96'(pkg_mode), 96'(f_mode(s)));
    chk(req, "pkg_status", 96'(pkg_status), 96'(f_stat(s)));
    chk(req, "pkg_payload", pkg_payload, ep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, c0, p0;
    repeat (3) tick;
    // R1: reset state
    chk("R1", "valid", 96'(pkg_valid), 0);
    chk("R1", "payload", pkg_payload, 0);
    chk("R1", "flags", 96'({cal_evt, pf_evt, sync_err, seq_err, len_err, pkg_bill}), 0);
    rst_n = 1'b1; tick;
    chk("R1", "num/mode/status", 96'({pkg_num, pkg_mode, pkg_status}), 0);

    // R3 and R7: all upper-bit patterns, order wraps five times
    for (int u = 0; u < 32; u++) begin
      v0 = vcnt;
      rdy_up;
      send_pkg({u[4:0], 3'(u % 6)}, u + 1, 16);
      rdy_down;
      chk("R3", "one valid", 96'(vcnt), 96'(v0 + 1));
      check_pkg("R3", u % 6, u + 1, 1'b0);
      chk("R7", "no seq_err in order", 96'(seq_err), 0);
    end

    // R4: bytes beyond the 16th ignored
    v0 = vcnt;
    rdy_up; send_pkg(8'h02, 40, 16); put(8'h80); put(8'h03); put(8'hEE); rdy_down;
    chk("R4", "single valid", 96'(vcnt), 96'(v0 + 1));
    check_pkg("R4", 2, 40, 1'b0);

    // R5: calibration header, with upper bits varied
    for (int u = 0; u < 4; u++) begin
      v0 = vcnt; c0 = ccnt;
      rdy_up; send_pkg({5'(u * 9), 3'd6}, 50, 16); rdy_down;
      chk("R5", "cal_evt count", 96'(ccnt), 96'(c0 + 1));
      chk("R5", "no valid", 96'(vcnt), 96'(v0));
      chk("R5", "no len_err", 96'(len_err), 0);
      check_pkg("R5", 2, 40, 1'b0);
    end

    // R2 and R9: wrong sync values
    for (int j = 0; j < 6; j++) begin
      logic [7:0] badv;
      case (j)
        0: badv = 8'h00; 1: badv = 8'h7F; 2: badv = 8'h81;
        3: badv = 8'hFF; 4: badv = 8'h08; default: badv = 8'h40;
      endcase
      v0 = vcnt; c0 = ccnt;
      rdy_up; send_raw(badv, 8'h03, 60, 0, 16);
      chk("R2", "sync_err set", 96'(sync_err), 1);
      rdy_down;
      chk("R2", "sync_err held", 96'(sync_err), 1);
      chk("R2", "no valid", 96'(vcnt), 96'(v0));
      check_pkg("R2", 2, 40, 1'b0);
      rdy_up;
      chk("R9", "sync_err cleared", 96'(sync_err), 0);
      rdy_down;
    end

    // R7: order break, still captured; then recovery and wrap
    v0 = vcnt;
    rdy_up; send_pkg(8'h04, 70, 16); rdy_down;
    chk("R7", "seq_err on skip", 96'(seq_err), 1);
    chk("R7", "captured", 96'(vcnt), 96'(v0 + 1));
    check_pkg("R7", 4, 70, 1'b0);
    rdy_up;
    chk("R9", "seq_err cleared", 96'(seq_err), 0);
    send_pkg(8'h05, 71, 16); rdy_down;
    chk("R7", "in order after break", 96'(seq_err), 0);
    rdy_up; send_pkg(8'h00, 72, 16); rdy_down;
    chk("R7", "wrap 5 to 0", 96'(seq_err), 0);

    // R8: truncated packages
    for (int j = 0; j < 5; j++) begin
      int n;
      n = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 3 : (j == 3) ? 8 : 15;
      v0 = vcnt;
      rdy_up; send_pkg(8'h01, 80 + n, n); rdy_down;
      chk("R8", "len_err", 96'(len_err), 1);
      chk("R8", "dropped", 96'(vcnt), 96'(v0));
      check_pkg("R8", 0, 72, 1'b0);
      rdy_up;
      chk("R9", "len_err cleared", 96'(len_err), 0);
      rdy_down;
      chk("R8", "empty burst no error", 96'(len_err), 0);
    end

    // R6: power-fail pair, then order resumes from last normal
    v0 = vcnt; p0 = pcnt;
    rdy_up; send_pkg(8'hAF, 90, 16); tick;
    chk("R6", "first billing valid", 96'(vcnt), 96'(v0 + 1));
    check_pkg("R6", 3, 90, 1'b1);
    send_pkg(8'h02, 91, 16); tick; rdy_down;
    chk("R6", "second billing valid", 96'(vcnt), 96'(v0 + 2));
    chk("R6", "pf_evt count", 96'(pcnt), 96'(p0 + 1));
    check_pkg("R6", 4, 91, 1'b1);
    chk("R6", "no seq_err", 96'(seq_err), 0);
    rdy_up; send_pkg(8'h01, 92, 16); rdy_down;
    chk("R6", "normal after billing in order", 96'(seq_err), 0);
    check_pkg("R6", 1, 92, 1'b0);

    // R8: billing pair cut inside the second package
    v0 = vcnt;
    rdy_up; send_pkg(8'h07, 93, 16); send_pkg(8'h00, 94, 5); rdy_down;
    chk("R8", "billing cut len_err", 96'(len_err), 1);
    chk("R8", "only first captured", 96'(vcnt), 96'(v0 + 1));
    check_pkg("R8", 3, 93, 1'b1);

    // R10: strobes while data-ready low, and in the rise cycle
    v0 = vcnt;
    send_pkg(8'h02, 99, 16); tick;
    chk("R10", "no valid while low", 96'(vcnt), 96'(v0));
    check_pkg("R10", 3, 93, 1'b1);
    data_rdy = 1'b1; rx_byte = 8'h80; rx_stb = 1'b1; tick; rx_stb = 1'b0;
    send_raw(8'h80, 8'h02, 98, 1, 16);
    chk("R10", "rise-cycle byte ignored", 96'(sync_err), 1);
    chk("R10", "no valid", 96'(vcnt), 96'(v0));
    rdy_down;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule